// File: doc/BRIEF.md
# Palette Channel Readback Sequencer

This block is the readable test port of a color palette. A processor writes a 3-bit pointer code into a test register. Each later processor read then returns one byte: either a fixed identification value or one color component (red, green or blue) of the 24-bit palette output word that is about to enter the DACs. Read data is taken from the full 8-bit component. The pointer moves forward after every read. A diagnostic routine can therefore walk the color channels of a pixel with back-to-back reads and does not have to rewrite the pointer between them.

The pointer is a four-state machine: `PTR_RED`, `PTR_GRN`, `PTR_BLU` and `PTR_ID`. The transitions are:

- **Load**: a write takes the machine to the state decoded from the pointer code.
- **Advance**: a read without a write moves `PTR_RED` to `PTR_GRN`, `PTR_GRN` to `PTR_BLU`, `PTR_BLU` to `PTR_RED`, and `PTR_ID` to `PTR_RED`.
- **Hold**: with neither strobe, the state stays as it is.

`PTR_ID` is left after one read. Advancing never brings the machine back to it. The pixel word is assumed to be stable while a read is in progress.

Top module: `palette_readback_seq`

## Requirements
- R1: After reset the pointer selects red and `rd_data` is 0x00.
- R2: A read registers the byte chosen by the pointer into `rd_data` on the clock edge where `rd_en` is high. The bytes are taken from `pix_word`: red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R3: Each read advances a color pointer from red to green, from green to blue, and from blue back to red.
- R4: Code 000 starts at red, code 001 starts at green and code 010 starts at blue. After code 001, three reads return green, blue and red.
- R5: Code 011 selects the identification byte 0x75. This byte does not depend on `pix_word`.
- R6: A read of the identification byte moves the pointer to red, and advancing never returns it to the identification byte. After code 011, six reads return ID, red, green, blue, red and green.
- R7: Only bits 2:0 of `wr_data` form the pointer code. Bits 7:3 have no effect on readback.
- R8: Codes 100 to 111 start the pointer at red.
- R9: `rd_data` keeps its value in every cycle without `rd_en`, and a write alone does not change it.
- R10: When `wr_en` and `rd_en` are high in the same cycle, the read returns the byte of the old pointer. The pointer then takes the written code and does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Test register write strobe |
| rd_en | input | 1 | Test port read strobe |
| wr_data | input | 8 | Write data; bits 2:0 carry the pointer code |
| pix_word | input | 24 | Palette output word (red, green, blue) |
| rd_data | output | 8 | Registered read data |

## Verification
A write to the test register and a read of the test port can fall in the same cycle. Two things happen at once in that cycle: the read uses the old pointer, and the write replaces the pointer that the read would otherwise have advanced. The bench provokes this collision for every combination of starting state and written code. It judges the result in two places: the byte returned in that cycle must belong to the old state, and the byte returned by the next plain read must belong to the written code, with no advance applied. Every write value is also swept with a run of reads that follows it. Each expected byte comes from an arithmetic pointer model kept in the bench.

// File: rtl/pal_rb_pkg.sv
package pal_rb_pkg;

    typedef enum logic [1:0] {
        PTR_RED = 2'd0,
        PTR_GRN = 2'd1,
        PTR_BLU = 2'd2,
        PTR_ID  = 2'd3
    } ptr_e;

    // Pointer code decode: 001 green, 010 blue, 011 ID, all others red.
    function automatic ptr_e decode_code(input logic [2:0] code);
        ptr_e r;
        unique case (code)
            3'b001:  r = PTR_GRN;
            3'b010:  r = PTR_BLU;
            3'b011:  r = PTR_ID;
            default: r = PTR_RED;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pal_ptr_fsm.sv
module pal_ptr_fsm
    import pal_rb_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [CODE_W-1:0] code,
    output ptr_e              state
);

    localparam int DEC_W = 3;

    ptr_e state_nx;
    logic [DEC_W-1:0] code_lo;

    assign code_lo = code[DEC_W-1:0];

    // Next-state logic: a write overrides an advance.
    always_comb begin
        state_nx = state;
        if (load) begin
            state_nx = decode_code(code_lo);
        end else if (adv) begin
            unique case (state)
                PTR_RED: state_nx = PTR_GRN;
                PTR_GRN: state_nx = PTR_BLU;
                PTR_BLU: state_nx = PTR_RED;
                PTR_ID:  state_nx = PTR_RED;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PTR_RED;
        else        state <= state_nx;
    end

    assert_blue_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PTR_BLU && adv && !load) |=> state == PTR_RED);

    assert_green_to_blue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PTR_GRN && adv && !load) |=> state == PTR_BLU);

    assert_id_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PTR_ID && adv && !load) |=> state == PTR_RED);

    assert_no_id_reentry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PTR_ID && !load) |=> state != PTR_ID);

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && adv && code_lo == 3'b011) |=> state == PTR_ID);

endmodule

// File: rtl/pal_byte_sel.sv
module pal_byte_sel
    import pal_rb_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter int          NUM_CH   = 3,
    parameter logic [7:0]  ID_VALUE = 8'h75
) (
    input  logic [NUM_CH*DATA_W-1:0] pix_word,
    input  ptr_e                     sel,
    output logic [DATA_W-1:0]        byte_out
);

    localparam int PIX_W = NUM_CH * DATA_W;

    logic [DATA_W-1:0] ch_byte [NUM_CH];

    // Channel 0 (red) occupies the most significant byte.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_byte[g] = pix_word[PIX_W - (g + 1) * DATA_W +: DATA_W];
    end

    always_comb begin
        unique case (sel)
            PTR_RED: byte_out = ch_byte[0];
            PTR_GRN: byte_out = ch_byte[1];
            PTR_BLU: byte_out = ch_byte[2];
            PTR_ID:  byte_out = DATA_W'(ID_VALUE);
        endcase
    end

endmodule

// File: rtl/palette_readback_seq.sv
module palette_readback_seq
    import pal_rb_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter int          NUM_CH   = 3,
    parameter int          CODE_W   = 3,
    parameter logic [7:0]  ID_VALUE = 8'h75
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [NUM_CH*DATA_W-1:0] pix_word,
    output logic [DATA_W-1:0]        rd_data
);

    ptr_e              ptr;
    logic [DATA_W-1:0] sel_byte;

    pal_ptr_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_en),
        .adv   (rd_en),
        .code  (wr_data[CODE_W-1:0]),
        .state (ptr)
    );

    pal_byte_sel #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .ID_VALUE(ID_VALUE)) u_sel (
        .pix_word (pix_word),
        .sel      (ptr),
        .byte_out (sel_byte)
    );

    // Output register: loaded only by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel_byte;
    end

    assert_hold_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_id_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ptr == PTR_ID) |=> rd_data == DATA_W'(ID_VALUE));

    assert_red_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ptr == PTR_RED) |=> rd_data == $past(pix_word[NUM_CH*DATA_W-1 -: DATA_W]));

endmodule

// File: tb/sim_palette_readback_seq.sv
module sim_palette_readback_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [23:0] pix_word = '0;
    logic [7:0]  rd_data;

    int n_vec = 0;
    int n_bad = 0;
    int mptr  = 0;   // model pointer: 0 red, 1 green, 2 blue, 3 ID
    int k     = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    palette_readback_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .pix_word(pix_word), .rd_data(rd_data)
    );

    function automatic int code_start(input logic [7:0] v);
        int c = int'(v) % 8;
        if (c >= 1 && c <= 3) return c;
        return 0;
    endfunction

    function automatic logic [7:0] exp_byte(input int p, input logic [23:0] w);
        if (p == 3) return 8'h75;
        return w[23 - 8*p -: 8];
    endfunction

    function automatic logic [23:0] mk_pix(input int n);
        return {8'(n * 37 + 1), 8'(n * 91 + 5), 8'(n * 13 + 200)};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        mptr = code_start(v);
    endtask

    task automatic do_read(input string req);
        logic [23:0] w = mk_pix(k);
        logic [7:0]  e;
        k++;
        @(negedge clk);
        rd_en = 1'b1; pix_word = w;
        e = exp_byte(mptr, w);
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, e);
        mptr = (mptr == 3) ? 0 : (mptr + 1) % 3;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", rd_data, 8'h00);
        rst_n = 1'b1;
        mptr = 0;
        do_read("R1");  // red first after reset

        // R4: code 001 gives green, blue, red
        do_write(8'h01);
        do_read("R4"); do_read("R4"); do_read("R4");

        // R6: code 011 gives ID, R, G, B, R, G
        do_write(8'h03);
        for (int i = 0; i < 6; i++) do_read("R6");

        // R5: ID independent of pixel word
        do_write(8'h03);
        @(negedge clk); rd_en = 1'b1; pix_word = 24'h000000;
        @(negedge clk); rd_en = 1'b0; check("R5", rd_data, 8'h75);

        // R9: a write alone does not disturb rd_data, and idle cycles hold it
        do_write(8'h02);
        check("R9", rd_data, 8'h75);
        repeat (3) @(negedge clk);
        check("R9", rd_data, 8'h75);

        // R2/R3/R7/R8: sweep every write value followed by four reads
        for (int v = 0; v < 256; v++) begin
            do_write(8'(v));
            do_read((v % 8) >= 4 ? "R8" : ((v / 8) != 0 ? "R7" : "R2"));
            for (int r = 0; r < 3; r++) do_read("R3");
        end

        // R10: simultaneous write and read, every start state by every code
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 8; c++) begin
                logic [23:0] w;
                do_write(8'(s));
                w = mk_pix(k); k++;
                @(negedge clk);
                wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'(c | 8'hA8); pix_word = w;
                @(negedge clk);
                wr_en = 1'b0; rd_en = 1'b0;
                check("R10", rd_data, exp_byte(s, w));
                mptr = code_start(8'(c));
                do_read("R10");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule